// File: doc/BRIEF.md
# Burst-Refill Rate-Matching Byte Buffer

This block sits between a bursty memory source and a steady byte consumer, and both sides run on one clock. Its store is a circular queue with a write pointer and a read pointer. The pointers are one bit wider than the address, and the fill level is their difference. The consumer sees a ready/valid byte stream. The head byte is presented whenever the queue holds data. A byte is removed on each clock edge where the consumer is ready.

A refill controller watches the fill level. When the level falls below `REFILL_THRESH`, the controller raises a burst request toward memory. It holds the request until the memory grants it. It then counts `BURST_LEN` returned beats before it may ask again, so only one burst is ever in flight. The memory may take a variable time to grant and to return data. The threshold is therefore chosen so that the stored bytes last through the worst wait, and so that a whole burst always fits. An elaboration check rejects a threshold plus burst length that exceeds the depth.

Sticky overflow and underflow flags record protocol errors until reset. Overflow means a beat arrived while the queue was full. Underflow means the consumer was ready while the queue was empty, after the first byte had ever been stored.

Top module: `burst_refill_buf`

## Requirements
- R1: While reset is applied and right after it is released, empty_o=1, full_o=0, level_o=0, out_valid_o=0, mem_req_o=0, overflow_o=0 and underflow_o=0.
- R2: Bytes leave on out_data_o in exactly the order in which accepted beats entered on mem_data_i.
- R3: level_o equals accepted writes minus completed reads and stays within 0..DEPTH. full_o is 1 exactly when level_o=DEPTH, and empty_o is 1 exactly when level_o=0.
- R4: mem_req_o rises only in the cycle after one in which level_o was below REFILL_THRESH with no burst in progress. Once raised, it stays high until a cycle with mem_gnt_i=1. It does not rise while level_o is at or above REFILL_THRESH.
- R5: After the grant cycle, the burst is complete once BURST_LEN cycles with mem_valid_i=1 have been seen, and these cycles may have gaps between them. mem_req_o stays low from the grant until that completion. A beat that arrives outside a burst is still stored if there is room.
- R6: Elaboration fails unless REFILL_THRESH is at least 1, REFILL_THRESH+BURST_LEN is at most DEPTH, and DEPTH is a power of two. A beat belonging to a granted burst never meets a full queue, so refill alone can never overflow.
- R7: out_valid_o equals not empty_o, and out_data_o is the oldest stored byte. A byte is removed only on an edge where out_valid_o and out_ready_i are both 1. With out_ready_i low, the level does not fall.
- R8: A beat with mem_valid_i=1 while full_o=1 is dropped: the level and the stored data are unchanged. overflow_o then sets and stays set until reset.
- R9: out_ready_i=1 while empty_o=1 sets underflow_o, but only once at least one byte has been stored since reset. underflow_o then stays set until reset, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_req_o | output | 1 | Burst request toward memory, held until granted |
| mem_gnt_i | input | 1 | One-cycle grant accepting the pending request |
| mem_valid_i | input | 1 | Returned data beat strobe |
| mem_data_i | input | DATA_W | Returned data beat |
| out_valid_o | output | 1 | Head byte available |
| out_ready_i | input | 1 | Consumer takes the head byte this edge |
| out_data_o | output | DATA_W | Head byte |
| level_o | output | $clog2(DEPTH)+1 | Number of stored bytes |
| full_o | output | 1 | Queue holds DEPTH bytes |
| empty_o | output | 1 | Queue holds no bytes |
| overflow_o | output | 1 | Sticky: beat arrived while full |
| underflow_o | output | 1 | Sticky: consumer ready while empty after priming |

## Verification
The bench delays the grant for many cycles and spreads burst beats apart with gaps. A controller that drops its request early would stall. One that counts beats from the wrong cycle would issue a second request in the middle of a burst. The bench fills the queue to exactly DEPTH with unsolicited beats and then adds one more. Pointers without the extra bit would report this state as empty, and a missing write guard would corrupt the oldest byte, so the drain order would come out wrong. Other runs use random memory latency up to the stated maximum against a consumer that reads once every four cycles. A wrong threshold comparison would then show up as a level above THRESH+BURST-1 or as a sticky error flag. Underflow is tested with the consumer ready before the first byte is stored, where the flag must stay low, and again after a full drain, where it must set and then survive idle cycles.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
  typedef enum logic [1:0] {
    RF_IDLE = 2'd0,
    RF_REQ  = 2'd1,
    RF_DATA = 2'd2
  } refill_st_e;
endpackage

// File: rtl/rbuf_ptrs.sv
module rbuf_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [PW-1:0] wptr_q, rptr_q;

  assign level_o = wptr_q - rptr_q;
  assign empty_o = (wptr_q == rptr_q);
  // extra MSB separates full from empty when address bits match
  assign full_o  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign wr_en_o = wr_req_i && !full_o;
  assign rd_en_o = rd_req_i && !empty_o;
  assign waddr_o = wptr_q[AW-1:0];
  assign raddr_o = rptr_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_en_o) wptr_q <= wptr_q + 1'b1;
      if (rd_en_o) rptr_q <= rptr_q + 1'b1;
    end
  end

  assert_level_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= PW'(DEPTH));
  assert_level_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && !rd_en_o |=> level_o == $past(level_o) + 1'b1);
  assert_level_down_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o && !wr_en_o |=> level_o == $past(level_o) - 1'b1);
  assert_full_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_req_i |=> wptr_q == $past(wptr_q));
  assert_empty_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_req_i |=> rptr_q == $past(rptr_q));
endmodule

// File: rtl/rbuf_store.sv
module rbuf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rbuf_refill.sv
module rbuf_refill
  import rbuf_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int BURST_LEN     = 8,
  parameter int REFILL_THRESH = 8,
  localparam int PW = $clog2(DEPTH) + 1,
  localparam int CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] level_i,
  input  logic          gnt_i,
  input  logic          beat_i,
  output logic          req_o,
  output logic          busy_o
);
  refill_st_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          low;

  assign low = level_i < PW'(REFILL_THRESH);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      RF_IDLE: if (low) st_d = RF_REQ;
      RF_REQ: begin
        if (gnt_i) begin
          st_d  = RF_DATA;
          cnt_d = '0;
        end
      end
      RF_DATA: begin
        if (beat_i) begin
          if (cnt_q == CW'(BURST_LEN - 1)) st_d = RF_IDLE;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = RF_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RF_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign req_o  = (st_q == RF_REQ);
  assign busy_o = (st_q == RF_DATA);

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !gnt_i |=> req_o);
  assert_req_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(level_i) < PW'(REFILL_THRESH));
  assert_req_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && gnt_i |=> !req_o);
  assert_one_burst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_o);
endmodule

// File: rtl/burst_refill_buf.sv
module burst_refill_buf #(
  parameter int DATA_W        = 8,
  parameter int DEPTH         = 16,
  parameter int BURST_LEN     = 8,
  parameter int REFILL_THRESH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [PW-1:0]     level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  // R6: the whole burst must fit above the trigger level
  if (REFILL_THRESH < 1 || REFILL_THRESH + BURST_LEN > DEPTH) begin : g_bad_thresh
    $error("refill threshold plus burst length exceeds depth");
  end
  if ((1 << AW) != DEPTH) begin : g_bad_depth
    $error("depth must be a power of two");
  end

  logic          wr_en, rd_en, busy;
  logic [AW-1:0] waddr, raddr;
  logic          primed_q, ovf_q, udf_q;

  rbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (mem_valid_i),
    .rd_req_i (out_ready_i),
    .wr_en_o  (wr_en),
    .rd_en_o  (rd_en),
    .waddr_o  (waddr),
    .raddr_o  (raddr),
    .level_o  (level_o),
    .full_o   (full_o),
    .empty_o  (empty_o)
  );

  rbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (waddr),
    .wdata_i (mem_data_i),
    .raddr_i (raddr),
    .rdata_o (out_data_o)
  );

  rbuf_refill #(
    .DEPTH(DEPTH), .BURST_LEN(BURST_LEN), .REFILL_THRESH(REFILL_THRESH)
  ) u_refill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level_o),
    .gnt_i   (mem_gnt_i),
    .beat_i  (mem_valid_i),
    .req_o   (mem_req_o),
    .busy_o  (busy)
  );

  assign out_valid_o = !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
    end else begin
      if (wr_en) primed_q <= 1'b1;
      if (mem_valid_i && full_o) ovf_q <= 1'b1;
      if (out_ready_i && empty_o && primed_q) udf_q <= 1'b1;
    end
  end

  assign overflow_o  = ovf_q;
  assign underflow_o = udf_q;

  assert_sticky_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  assert_ovf_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(full_o) && $past(mem_valid_i));
  assert_sticky_udf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
  assert_udf_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> $past(empty_o) && $past(out_ready_i));
  assert_burst_fits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && mem_valid_i |-> !full_o);
  assert_flags_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

// File: tb/tb_burst_refill_buf.sv
module tb_burst_refill_buf;
  localparam int DW      = 8;
  localparam int DEPTH   = 16;
  localparam int BURST   = 8;
  localparam int THRESH  = 8;
  localparam int LAT_MAX = 12;
  localparam int PW      = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mem_req_o, mem_gnt_i, mem_valid_i;
  logic [DW-1:0] mem_data_i;
  logic          out_valid_o, out_ready_i;
  logic [DW-1:0] out_data_o;
  logic [PW-1:0] level_o;
  logic          full_o, empty_o, overflow_o, underflow_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] seq = 8'h00;

  always #5 clk = ~clk;

  burst_refill_buf #(
    .DATA_W(DW), .DEPTH(DEPTH), .BURST_LEN(BURST), .REFILL_THRESH(THRESH)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i),
    .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .level_o(level_o), .full_o(full_o), .empty_o(empty_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    mem_gnt_i = 1'b0; mem_valid_i = 1'b0; mem_data_i = '0; out_ready_i = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk("R1 req in reset", mem_req_o, 0);
    chk("R1 udf in reset", underflow_o, 0);
    rst_ni = 1'b1;
    chk("R1 empty", empty_o, 1);
    chk("R1 full", full_o, 0);
    chk("R1 level", level_o, 0);
    chk("R1 valid", out_valid_o, 0);
    chk("R1 overflow", overflow_o, 0);
  endtask

  task automatic send_beat(input logic [DW-1:0] b, input bit keep);
    mem_valid_i = 1'b1; mem_data_i = b;
    if (keep) exp_q.push_back(b);
    @(negedge clk);
    mem_valid_i = 1'b0;
  endtask

  task automatic pop_one(input string tag);
    chk({tag, " R7 valid"}, out_valid_o, 1);
    chk({tag, " R2 order"}, out_data_o, exp_q.pop_front());
    out_ready_i = 1'b1;
    @(negedge clk);
    out_ready_i = 1'b0;
  endtask

  // Request hold, gapped burst, threshold and ready gating
  task automatic t_request_handshake();
    do_reset();
    out_ready_i = 1'b1;                     // ready before any byte: no underflow
    @(negedge clk);
    out_ready_i = 1'b0;
    chk("R9 unprimed ready", underflow_o, 0);
    for (int i = 0; i < 10; i++) begin
      chk("R4 req held", mem_req_o, 1);
      @(negedge clk);
    end
    mem_gnt_i = 1'b1; @(negedge clk); mem_gnt_i = 1'b0;
    chk("R5 req drops on grant", mem_req_o, 0);
    for (int k = 0; k < BURST; k++) begin
      send_beat(seq, 1'b1); seq++;
      chk("R5 no req mid burst", mem_req_o, 0);
      @(negedge clk);                       // gap cycle
      chk("R5 no req in gap", mem_req_o, 0);
    end
    chk("R3 level after burst", level_o, BURST);
    repeat (4) @(negedge clk);
    chk("R4 no req at threshold", mem_req_o, 0);
    chk("R7 no read without ready", level_o, BURST);
    pop_one("hs");
    chk("R3 level after pop", level_o, BURST - 1);
    @(negedge clk);
    chk("R4 req below threshold", mem_req_o, 1);
  endtask

  // Continues from t_request_handshake: fill to full, overflow, drain, underflow
  task automatic t_overflow_underflow();
    mem_gnt_i = 1'b1; @(negedge clk); mem_gnt_i = 1'b0;
    for (int k = 0; k < BURST; k++) begin send_beat(seq, 1'b1); seq++; end
    chk("R3 level 15", level_o, THRESH - 1 + BURST);
    chk("R6 burst no overflow", overflow_o, 0);
    send_beat(seq, 1'b1); seq++;            // unsolicited, fits
    chk("R3 full flag", full_o, 1);
    chk("R3 level full", level_o, DEPTH);
    chk("R8 no ovf yet", overflow_o, 0);
    send_beat(8'hEE, 1'b0);                 // dropped
    chk("R8 overflow set", overflow_o, 1);
    chk("R8 level unchanged", level_o, DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_one("drain");
    chk("R3 empty after drain", empty_o, 1);
    chk("R7 valid low", out_valid_o, 0);
    chk("R8 overflow sticky", overflow_o, 1);
    chk("R9 no udf yet", underflow_o, 0);
    out_ready_i = 1'b1; @(negedge clk); out_ready_i = 1'b0;
    chk("R9 underflow set", underflow_o, 1);
    chk("R9 level stays 0", level_o, 0);
    repeat (3) @(negedge clk);
    chk("R9 underflow sticky", underflow_o, 1);
    do_reset();
    chk("R9 cleared by reset", underflow_o, 0);
  endtask

  // Random grant latency, consumer ready one cycle in four
  task automatic t_random_stream();
    int ms = 0, wc = 0, nb = 0, got = 0, maxlvl = 0;
    do_reset();
    for (int cyc = 0; cyc < 20000 && got < 300; cyc++) begin
      out_ready_i = (cyc % 4 == 3);
      if (out_ready_i && out_valid_o) begin
        chk("R2 random order", out_data_o, exp_q.pop_front());
        got++;
      end
      mem_gnt_i = 1'b0; mem_valid_i = 1'b0;
      case (ms)
        0: if (mem_req_o) begin wc = $urandom_range(0, LAT_MAX); ms = 1; end
        1: if (wc == 0) begin mem_gnt_i = 1'b1; ms = 2; nb = 0; end else wc--;
        default: begin
          if (mem_req_o) chk("R5 req during burst", 1, 0);
          mem_valid_i = 1'b1; mem_data_i = seq; exp_q.push_back(seq); seq++;
          nb++;
          if (nb == BURST) ms = 0;
        end
      endcase
      if (int'(level_o) > maxlvl) maxlvl = int'(level_o);
      @(negedge clk);
    end
    out_ready_i = 1'b0; mem_valid_i = 1'b0; mem_gnt_i = 1'b0;
    chk("R2 bytes received", got, 300);
    chk("R6 peak level bound", int'(maxlvl <= THRESH - 1 + BURST), 1);
    chk("R6 no overflow", overflow_o, 0);
    chk("R9 no underflow", underflow_o, 0);
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mem_gnt_i = 1'b0; mem_valid_i = 1'b0; mem_data_i = '0; out_ready_i = 1'b0;
    t_request_handshake();
    t_overflow_underflow();
    t_random_stream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule